// File: doc/BRIEF.md
# Edge-Clocked Serial Fault Frame Transmitter

This block reports the fault state of a six-plug heater controller to a host over a single wire. It holds an 8-bit fault register and sends it out as a frame. There is no free-running bit clock: every falling edge of the filtered command signal arrives as a one-cycle strobe, and each strobe moves the frame on by exactly one bit. The output is a single drive-low control. When it is inactive, the line is pulled high externally, so a released line and a logic 1 look the same.

A frame takes ten strobes. It starts with one low start bit, then sends register bits 1 to 8 in that order, then one high stop bit. After that the line stays released for the rest of a fixed cadence of FRAME_EDGES strobes (default 32), and then the next frame starts. The first frame starts at the very first strobe after reset.

The register changes only once per cadence, at the first idle strobe. Faults that arrive at any other time are kept as sticky pending bits until that strobe. Overcurrent flags are latched until reset. Bit 7 selects how bits 1 to 6 are read: open-load when it is low, overcurrent when it is high.

Top module: `fault_frame_tx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `do_pull_low` is 0. Reset clears the register, the pending faults, the latched overcurrents and the strobe position.
- R2: The first frame after reset is sent from a cleared register, so the first nine strobes after reset each drive the line low.
- R3: Strobe position 0 drives the line low (`do_pull_low`=1). Position k, for k from 1 to 8, sends register bit k. Bit k comes from plug k for k≤6, from the class bit for k=7 and from the module bit for k=8. A 0 bit drives the line low and a 1 bit releases it.
- R4: Position 9 (the stop bit) and positions 10 to FRAME_EDGES-1 (idle) release the line.
- R5: The strobe position wraps from FRAME_EDGES-1 to 0, so a start bit comes every FRAME_EDGES strobes.
- R6: `do_pull_low` changes only in the cycle that follows a strobe. Without a strobe it holds its value.
- R7: The register is written only at the strobe for position 10. A fault seen at any other time is held pending and appears in the next frame, never in the frame already under way.
- R8: If no overcurrent is latched and there is no battery undervoltage, bits 1 to 6 are the open-load flags seen since the previous merge, and bit 7 is 0.
- R9: Any overcurrent pulse is latched until reset. While an overcurrent is latched, bits 1 to 6 show the latched overcurrent plugs, bit 7 is 1, and open-load flags are hidden.
- R10: Bit 8 is set by a module fault or by a battery undervoltage. A battery undervoltage with no latched overcurrent gives bits 7 and 8 high and bits 1 to 6 low.
- R11: Pending faults are cleared at each merge. A non-latched fault that has gone away is absent from the frame after the one that reported it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_stb | input | 1 | One-cycle strobe per filtered falling edge of the command signal |
| open_load | input | 6 | Open-load flags, bit i = plug i+1 |
| over_cur | input | 6 | Overcurrent flags, bit i = plug i+1 |
| batt_uv | input | 1 | Battery undervoltage flag |
| module_fault | input | 1 | Combined module fault flag |
| do_pull_low | output | 1 | 1 drives the diagnostic line low, 0 releases it |

## Verification
Each strobe is captured on a clock edge, and `do_pull_low` shows the matching bit one register later, in the very next cycle. The bench therefore compares it 1 ns after every rising edge against a reference that advances the strobe position on that same edge. On cycles without a strobe it checks that the value held. A fault change is merged at the position-10 strobe and can only appear in the frame that starts at the next wrap. For this reason the directed cases hold their inputs across whole frames, or pulse them at a known position, and compare the captured byte one or two frames later. For multi-frame inputs this means the third frame after the change.

// File: rtl/ffx_pkg.sv
package ffx_pkg;

    // Plug count fixes the register layout: plugs, class bit, module bit.
    localparam int unsigned PLUGS     = 6;
    localparam int unsigned REG_W     = PLUGS + 2;
    localparam int unsigned STOP_POS  = REG_W + 1;
    localparam int unsigned MERGE_POS = REG_W + 2;

    typedef enum logic [1:0] {
        SLOT_START,
        SLOT_DATA,
        SLOT_STOP,
        SLOT_IDLE
    } slot_e;

    typedef struct packed {
        logic             module_fault;
        logic             batt_uv;
        logic [PLUGS-1:0] over_cur;
        logic [PLUGS-1:0] open_load;
    } fault_evt_t;

    // Packed order puts plug bits at the LSBs: bit0 = plug 1 ... bit7 = module.
    typedef struct packed {
        logic             module_bit;
        logic             class_bit;
        logic [PLUGS-1:0] plug_bits;
    } fault_reg_t;

    function automatic slot_e slot_of(input int unsigned pos);
        if (pos == 0)
            return SLOT_START;
        else if (pos <= REG_W)
            return SLOT_DATA;
        else if (pos == STOP_POS)
            return SLOT_STOP;
        return SLOT_IDLE;
    endfunction

    // Class bit selects the meaning of the plug bits: 0 open-load, 1 overcurrent.
    function automatic fault_reg_t encode_faults(input fault_evt_t ev,
                                                 input logic [PLUGS-1:0] oc_hist);
        fault_reg_t       r;
        logic [PLUGS-1:0] oc_all;
        oc_all       = oc_hist | ev.over_cur;
        r.module_bit = ev.module_fault | ev.batt_uv;
        r.class_bit  = (|oc_all) | ev.batt_uv;
        if (|oc_all)
            r.plug_bits = oc_all;
        else if (ev.batt_uv)
            r.plug_bits = '0;
        else
            r.plug_bits = ev.open_load;
        return r;
    endfunction

endpackage

// File: rtl/ffx_cadence.sv
module ffx_cadence
    import ffx_pkg::*;
#(
    parameter int unsigned FRAME_EDGES = 32,
    parameter int unsigned CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_stb,
    output logic [CNT_W-1:0] pos_o,
    output slot_e            slot_o,
    output logic             merge_o
);

    localparam bit POW2 = (FRAME_EDGES == (1 << CNT_W));

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_next;

    generate
        if (POW2) begin : g_natural_wrap
            always_comb pos_next = pos_q + CNT_W'(1);
        end else begin : g_compare_wrap
            always_comb pos_next = (pos_q == CNT_W'(FRAME_EDGES - 1)) ? '0
                                                                      : pos_q + CNT_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (edge_stb)
            pos_q <= pos_next;
    end

    assign pos_o   = pos_q;
    assign slot_o  = slot_of(32'(pos_q));
    assign merge_o = edge_stb && (32'(pos_q) == MERGE_POS);

endmodule

// File: rtl/ffx_collect.sv
module ffx_collect
    import ffx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_evt_t evt_i,
    input  logic       merge_i,
    output fault_reg_t reg_o
);

    logic [PLUGS-1:0] oc_hist_q;
    fault_evt_t       pend_q;
    fault_evt_t       pend_all;
    fault_reg_t       reg_q;

    assign pend_all = fault_evt_t'(pend_q | evt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_hist_q <= '0;
            pend_q    <= '0;
            reg_q     <= '0;
        end else begin
            oc_hist_q <= oc_hist_q | evt_i.over_cur;
            if (merge_i) begin
                reg_q  <= encode_faults(pend_all, oc_hist_q);
                pend_q <= '0;
            end else begin
                pend_q <= pend_all;
            end
        end
    end

    assign reg_o = reg_q;

endmodule

// File: rtl/ffx_shifter.sv
module ffx_shifter
    import ffx_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_stb,
    input  logic [CNT_W-1:0] pos_i,
    input  slot_e            slot_i,
    input  fault_reg_t       reg_i,
    output logic             pull_low_o
);

    localparam int unsigned IDX_W = $clog2(REG_W);

    logic [REG_W-1:0] reg_v;
    logic [IDX_W-1:0] bit_idx;
    logic             next_pull;
    logic             pull_q;

    assign reg_v   = reg_i;
    assign bit_idx = IDX_W'(pos_i - CNT_W'(1));

    always_comb begin
        unique case (slot_i)
            SLOT_START: next_pull = 1'b1;
            SLOT_DATA:  next_pull = ~reg_v[bit_idx];
            SLOT_STOP:  next_pull = 1'b0;
            default:    next_pull = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pull_q <= 1'b0;
        else if (edge_stb)
            pull_q <= next_pull;
    end

    assign pull_low_o = pull_q;

endmodule

// File: rtl/fault_frame_tx.sv
module fault_frame_tx
    import ffx_pkg::*;
#(
    parameter int unsigned FRAME_EDGES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_stb,
    input  logic [PLUGS-1:0] open_load,
    input  logic [PLUGS-1:0] over_cur,
    input  logic             batt_uv,
    input  logic             module_fault,
    output logic             do_pull_low
);

    localparam int unsigned CNT_W = $clog2(FRAME_EDGES);

    logic [CNT_W-1:0] edge_pos;
    slot_e            edge_slot;
    logic             merge_now;
    fault_evt_t       evt;
    fault_reg_t       fault_reg;

    assign evt.module_fault = module_fault;
    assign evt.batt_uv      = batt_uv;
    assign evt.over_cur     = over_cur;
    assign evt.open_load    = open_load;

    ffx_cadence #(
        .FRAME_EDGES(FRAME_EDGES),
        .CNT_W      (CNT_W)
    ) u_cadence (
        .clk     (clk),
        .rst     (rst),
        .edge_stb(edge_stb),
        .pos_o   (edge_pos),
        .slot_o  (edge_slot),
        .merge_o (merge_now)
    );

    ffx_collect u_collect (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .merge_i(merge_now),
        .reg_o  (fault_reg)
    );

    ffx_shifter #(
        .CNT_W(CNT_W)
    ) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .edge_stb  (edge_stb),
        .pos_i     (edge_pos),
        .slot_i    (edge_slot),
        .reg_i     (fault_reg),
        .pull_low_o(do_pull_low)
    );

endmodule

// File: rtl/ffx_chk.sv
module ffx_chk
    import ffx_pkg::*;
#(
    parameter int unsigned FRAME_EDGES = 32,
    parameter int unsigned CNT_W       = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             edge_stb,
    input logic             do_pull_low,
    input logic [CNT_W-1:0] pos_q,
    input logic             merge,
    input logic [REG_W-1:0] reg_bits
);

    p_reset_release_r1: assert property (@(posedge clk)
        rst |=> (!do_pull_low && pos_q == '0));

    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && pos_q == '0) |=> do_pull_low);

    p_idle_release_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && 32'(pos_q) > REG_W) |=> !do_pull_low);

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && pos_q == CNT_W'(FRAME_EDGES - 1)) |=> (pos_q == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !edge_stb |=> $stable(do_pull_low));

    p_reg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !merge |=> $stable(reg_bits));

    p_uv_pair_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_bits[REG_W-2] && reg_bits[PLUGS-1:0] == '0) |-> reg_bits[REG_W-1]);

endmodule

bind fault_frame_tx ffx_chk #(
    .FRAME_EDGES(FRAME_EDGES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .edge_stb   (edge_stb),
    .do_pull_low(do_pull_low),
    .pos_q      (edge_pos),
    .merge      (merge_now),
    .reg_bits   (fault_reg)
);

// File: tb/sim_fault_frame_tx.sv
`timescale 1ns/1ps
module sim_fault_frame_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       edge_stb = 1'b0;
    logic [5:0] open_load = '0;
    logic [5:0] over_cur = '0;
    logic       batt_uv = 1'b0;
    logic       module_fault = 1'b0;
    logic       do_pull_low;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    int         m_pos = 0;
    int         m_frames = 0;
    logic [7:0] m_reg = '0;
    logic [5:0] m_pol = '0;
    logic       m_puv = 1'b0;
    logic       m_pmf = 1'b0;
    logic [5:0] m_och = '0;
    logic       m_out = 1'b0;
    logic [7:0] cap = '0;

    always #2 clk = ~clk;

    fault_frame_tx #(.FRAME_EDGES(32)) u0 (
        .clk(clk), .rst(rst), .edge_stb(edge_stb), .open_load(open_load),
        .over_cur(over_cur), .batt_uv(batt_uv), .module_fault(module_fault),
        .do_pull_low(do_pull_low)
    );

    function automatic logic [7:0] benc(input logic [5:0] ol, input logic [5:0] oc,
                                        input logic uv, input logic mf);
        logic [5:0] plugs;
        plugs = (oc != 0) ? oc : (uv ? 6'd0 : ol);
        return {mf | uv, (oc != 0) | uv, plugs};
    endfunction

    function automatic logic bit_for(input int pos, input logic [7:0] r);
        if (pos == 0) return 1'b1;
        if (pos <= 8) return ~r[pos-1];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic stb);
        if (rst) begin
            m_pos = 0; m_frames = 0; m_reg = '0; m_pol = '0; m_puv = 0;
            m_pmf = 0; m_och = '0; m_out = 0;
        end else begin
            if (stb) begin
                m_out = bit_for(m_pos, m_reg);
                if (m_pos == 10) begin
                    m_reg = benc(m_pol | open_load, m_och | over_cur,
                                 m_puv | batt_uv, m_pmf | module_fault);
                    m_pol = '0; m_puv = 0; m_pmf = 0;
                end else begin
                    m_pol |= open_load; m_puv |= batt_uv; m_pmf |= module_fault;
                end
                m_pos = (m_pos + 1) % 32;
                if (m_pos == 0) m_frames++;
            end else begin
                m_pol |= open_load; m_puv |= batt_uv; m_pmf |= module_fault;
            end
            m_och |= over_cur;
        end
    endtask

    task automatic step(input logic stb);
        string tag;
        int    p;
        p = m_pos;
        edge_stb = stb;
        if (rst) tag = "R1";
        else if (!stb) tag = "R6";
        else if (m_frames == 0) tag = "R2";
        else if (p == 0) tag = "R5";
        else if (p <= 8) tag = "R3";
        else tag = "R4";
        @(posedge clk);
        model(stb);
        #1;
        check(tag, {7'd0, do_pull_low}, {7'd0, m_out});
        if (stb && !rst && p >= 1 && p <= 8) cap[p-1] = ~do_pull_low;
        edge_stb = 1'b0;
    endtask

    task automatic run_frame(input int gap_max, input int pulse_at, input bit rnd);
        for (int e = 0; e < 32; e++) begin
            int p;
            int n;
            p = m_pos;
            if (rnd && $urandom_range(7, 0) == 0) begin
                open_load    = 6'($urandom);
                batt_uv      = ($urandom_range(3, 0) == 0);
                module_fault = 1'($urandom_range(1, 0));
                over_cur     = ($urandom_range(15, 0) == 0) ? 6'(1 << $urandom_range(5, 0)) : 6'd0;
            end
            step(1'b1);
            if (p == pulse_at) begin
                module_fault = 1'b1;
                step(1'b0);
                module_fault = 1'b0;
            end
            n = $urandom_range(gap_max, 0);
            for (int g = 0; g < n; g++) step(1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        step(1'b0);
        step(1'b0);
        check("R1", {7'd0, do_pull_low}, 8'd0);
        rst = 1'b0;
        step(1'b0);

        // R2 / R8: open-load present from the start; first frame still clear
        open_load = 6'b000101;
        run_frame(2, -1, 0);
        check("R2", cap, 8'h00);
        run_frame(2, -1, 0);
        check("R8", cap, 8'h05);

        // R10: battery undervoltage hides open-load, sets bits 7 and 8
        batt_uv = 1'b1;
        run_frame(1, -1, 0);
        run_frame(1, -1, 0);
        run_frame(1, -1, 0);
        check("R10", cap, 8'hC0);

        // R11: once cleared, faults drain out
        batt_uv = 1'b0;
        open_load = '0;
        run_frame(1, -1, 0);
        run_frame(1, -1, 0);
        run_frame(1, -1, 0);
        check("R11", cap, 8'h00);

        // R7: pulse during data bits; not in this frame, in the next
        run_frame(1, 3, 0);
        check("R7", cap, 8'h00);
        run_frame(1, -1, 0);
        check("R7", cap, 8'h80);
        run_frame(1, -1, 0);
        check("R11", cap, 8'h00);

        // R9: overcurrent latched, open-load hidden, stays after input clears
        open_load = 6'b110000;
        over_cur = 6'b000010;
        step(1'b0);
        over_cur = '0;
        run_frame(2, -1, 0);
        run_frame(2, -1, 0);
        run_frame(2, -1, 0);
        check("R9", cap, 8'h42);
        open_load = '0;
        run_frame(2, -1, 0);
        check("R9", cap, 8'h42);

        // R10: module fault adds bit 8
        module_fault = 1'b1;
        run_frame(1, -1, 0);
        run_frame(1, -1, 0);
        run_frame(1, -1, 0);
        check("R10", cap, 8'hC2);
        module_fault = 1'b0;

        // random traffic against the reference
        for (int f = 0; f < 12; f++) run_frame(3, -1, 1);

        // R1 / R2: reset mid-frame clears everything, including latched overcurrent
        open_load = '0; over_cur = '0; batt_uv = 0; module_fault = 0;
        for (int i = 0; i < 5; i++) step(1'b1);
        rst = 1'b1;
        step(1'b0);
        step(1'b0);
        check("R1", {7'd0, do_pull_low}, 8'd0);
        rst = 1'b0;
        step(1'b0);
        run_frame(1, -1, 0);
        check("R2", cap, 8'h00);
        run_frame(1, -1, 0);
        check("R1", cap, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule